// File: doc/BRIEF.md
# Directory Home Controller for MSI Coherence

This block is the home side of a two-level MSI coherence scheme. For every address of a small shared space it keeps one data word, the state it believes each of N child caches holds (I, S or M), and for each child a wait field that says whether the home has asked that child to step down and to which state. Children send it two kinds of message: upgrade requests (a child wants S or M) and downgrade responses (a child has dropped to a lower state, either on request or on its own, carrying its data when it held M).

An upgrade request is granted only when no child has a wait pending on that address and every sibling's recorded state can coexist with the requested one. If that does not hold, the home asks one blocking sibling per cycle to downgrade, marks the wait, and leaves the request at the head of the child's queue. The request is retried every cycle until it is granted. Downgrade responses are always accepted ahead of any request, so they can never be held up by requests. The outgoing side is a single registered message port that carries either a grant or a downgrade request.

After reset the block clears its whole directory and data store, one address per cycle, before it serves any traffic.

Top module: `dir_home`

## Requirements
- R1: Child states are encoded I=0, S=1, M=2. A sibling blocks a request for S only if it is recorded in M, and blocks a request for M if it is recorded in S or M. Any block stops the grant.
- R2: A request is granted in the cycle it is presented when no wait is pending on its address and no sibling blocks it. In that cycle `ureq_take` is 1. On the next cycle the message port shows `msg_grant`=1 with the requester, the address and the granted state, and the requester is recorded in that state.
- R3: When a request cannot be granted, the lowest-numbered sibling that blocks it and has no pending wait is sent a downgrade request (`msg_grant`=0). The target is I when M was requested and S when S was requested. That sibling's wait is set to that target. Only one such message is sent per cycle, and none goes to a sibling whose wait is already pending.
- R4: A downgrade response writes its data into the store only if the responding child is recorded in M. The child is then recorded in the responded state.
- R5: A downgrade response clears that child's wait only if the awaited target is at least the responded state. While any wait on an address is pending, no request to that address is granted.
- R6: At most one child is ever recorded in M for an address.
- R7: A cycle with a valid downgrade response serves that response, and no request is taken in that cycle.
- R8: A grant carries store data (`msg_with_data`=1) exactly when the requester was recorded in I.
- R9: For the DEPTH cycles after reset, no request is taken and no message is sent. Afterwards every child is recorded in I, with no waits, and every data word is zero.
- R10: A request that is not granted is not taken (`ureq_take`=0) and is retried each cycle while it stays presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ureq_valid | input | 1 | Upgrade request present at queue head |
| ureq_child | input | CW | Requesting child |
| ureq_addr | input | ADDR_W | Requested address |
| ureq_goal | input | 2 | Requested state (S or M) |
| ureq_take | output | 1 | Request granted and dequeued this cycle |
| drsp_valid | input | 1 | Downgrade response present |
| drsp_child | input | CW | Responding child |
| drsp_addr | input | ADDR_W | Address of the response |
| drsp_state | input | 2 | State the child has dropped to |
| drsp_data | input | DATA_W | Data carried by the response |
| msg_valid | output | 1 | Outgoing message valid |
| msg_grant | output | 1 | 1 = upgrade grant, 0 = downgrade request |
| msg_child | output | CW | Destination child |
| msg_addr | output | ADDR_W | Message address |
| msg_state | output | 2 | Granted or target state |
| msg_data | output | DATA_W | Store data for a grant |
| msg_with_data | output | 1 | Grant carries valid data |

## Verification
The assertions take for granted that children behave as legal caches. A child asks only for a state above the one it is recorded in. It never responds with a state at or above its recorded one. It does not step down on its own at an address where its own upgrade request is waiting. Both inputs stay quiet during the initial clearing. The stimulus follows these rules by keeping a model of each child's recorded state. It answers a downgrade request only when the child is still above the target, and otherwise drops it. Spontaneous downgrades are drawn only for pairs of child and address that are not waiting on an upgrade.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_M = 2'd2
  } cstate_t;

  typedef struct packed {
    logic    pend;
    cstate_t goal;
  } cwait_t;

  // a sibling may coexist with a holder of state y only at or below this
  function automatic cstate_t sibling_limit(cstate_t y);
    return (y == ST_M) ? ST_I : ST_S;
  endfunction

endpackage

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int N_CHILD = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input  logic                  clk,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [DATA_W-1:0]     rd_data,
  output cstate_t [N_CHILD-1:0] rd_dir,
  output cwait_t  [N_CHILD-1:0] rd_wait,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  cstate_t [N_CHILD-1:0] wr_dir,
  input  cwait_t  [N_CHILD-1:0] wr_wait,
  input  logic                  dat_we,
  input  logic [DATA_W-1:0]     dat_wdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0]     mem_q  [DEPTH];
  cstate_t [N_CHILD-1:0] dir_q  [DEPTH];
  cwait_t  [N_CHILD-1:0] wait_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      dir_q[wr_addr]  <= wr_dir;
      wait_q[wr_addr] <= wr_wait;
    end
    if (dat_we) begin
      mem_q[wr_addr] <= dat_wdata;
    end
  end

  assign rd_data = mem_q[rd_addr];
  assign rd_dir  = dir_q[rd_addr];
  assign rd_wait = wait_q[rd_addr];

endmodule

// File: rtl/dir_decide.sv
module dir_decide
  import dir_pkg::*;
#(
  parameter int N_CHILD = 4,
  localparam int CW = (N_CHILD > 1) ? $clog2(N_CHILD) : 1
) (
  input  cstate_t [N_CHILD-1:0] cur_dir,
  input  cwait_t  [N_CHILD-1:0] cur_wait,
  input  logic [CW-1:0]         req_child,
  input  cstate_t               req_goal,
  output logic                  grant,
  output logic                  dn_hit,
  output logic [CW-1:0]         dn_child,
  output cstate_t               dn_goal
);
  logic [N_CHILD-1:0] pend_v;
  logic [N_CHILD-1:0] block_v;
  logic [N_CHILD-1:0] elig_v;

  assign dn_goal = sibling_limit(req_goal);

  for (genvar i = 0; i < N_CHILD; i++) begin : g_child
    logic is_self;
    assign is_self    = (req_child == CW'(i));
    assign pend_v[i]  = cur_wait[i].pend;
    assign block_v[i] = !is_self && (cur_dir[i] > dn_goal);
    assign elig_v[i]  = block_v[i] && !pend_v[i];
  end

  assign grant  = (pend_v == '0) && (block_v == '0);
  assign dn_hit = (elig_v != '0);

  // lowest-numbered eligible sibling first
  always_comb begin
    dn_child = '0;
    for (int i = N_CHILD - 1; i >= 0; i--) begin
      if (elig_v[i]) dn_child = CW'(i);
    end
  end

endmodule

// File: rtl/dir_home.sv
module dir_home
  import dir_pkg::*;
#(
  parameter int N_CHILD = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16,
  localparam int CW     = (N_CHILD > 1) ? $clog2(N_CHILD) : 1,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ureq_valid,
  input  logic [CW-1:0]     ureq_child,
  input  logic [ADDR_W-1:0] ureq_addr,
  input  logic [1:0]        ureq_goal,
  output logic              ureq_take,
  input  logic              drsp_valid,
  input  logic [CW-1:0]     drsp_child,
  input  logic [ADDR_W-1:0] drsp_addr,
  input  logic [1:0]        drsp_state,
  input  logic [DATA_W-1:0] drsp_data,
  output logic              msg_valid,
  output logic              msg_grant,
  output logic [CW-1:0]     msg_child,
  output logic [ADDR_W-1:0] msg_addr,
  output logic [1:0]        msg_state,
  output logic [DATA_W-1:0] msg_data,
  output logic              msg_with_data
);
  logic              init_busy;
  logic [ADDR_W-1:0] init_idx;
  logic [ADDR_W-1:0] sel_addr;

  logic [DATA_W-1:0]     rd_data;
  cstate_t [N_CHILD-1:0] rd_dir;
  cwait_t  [N_CHILD-1:0] rd_wait;
  logic                  wr_en;
  cstate_t [N_CHILD-1:0] wr_dir;
  cwait_t  [N_CHILD-1:0] wr_wait;
  logic                  dat_we;
  logic [DATA_W-1:0]     dat_wdata;

  logic    grant, dn_hit;
  logic [CW-1:0] dn_child;
  cstate_t dn_goal;
  cstate_t req_goal, rsp_state;

  logic serve_rsp, serve_req, do_grant, do_dn;

  assign req_goal  = cstate_t'(ureq_goal);
  assign rsp_state = cstate_t'(drsp_state);

  assign sel_addr  = init_busy ? init_idx : (drsp_valid ? drsp_addr : ureq_addr);
  assign serve_rsp = !init_busy && drsp_valid;
  assign serve_req = !init_busy && !drsp_valid && ureq_valid;
  assign do_grant  = serve_req && grant;
  assign do_dn     = serve_req && !grant && dn_hit;
  assign ureq_take = do_grant;

  dir_store #(.N_CHILD(N_CHILD), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rd_addr  (sel_addr),
    .rd_data  (rd_data),
    .rd_dir   (rd_dir),
    .rd_wait  (rd_wait),
    .wr_en    (wr_en),
    .wr_addr  (sel_addr),
    .wr_dir   (wr_dir),
    .wr_wait  (wr_wait),
    .dat_we   (dat_we),
    .dat_wdata(dat_wdata)
  );

  dir_decide #(.N_CHILD(N_CHILD)) u_decide (
    .cur_dir  (rd_dir),
    .cur_wait (rd_wait),
    .req_child(ureq_child),
    .req_goal (req_goal),
    .grant    (grant),
    .dn_hit   (dn_hit),
    .dn_child (dn_child),
    .dn_goal  (dn_goal)
  );

  // next directory entry: one read-modify-write per cycle
  always_comb begin
    wr_en     = 1'b0;
    dat_we    = 1'b0;
    wr_dir    = rd_dir;
    wr_wait   = rd_wait;
    dat_wdata = drsp_data;
    if (init_busy) begin
      wr_en     = 1'b1;
      dat_we    = 1'b1;
      dat_wdata = '0;
      wr_wait   = '0;
      for (int i = 0; i < N_CHILD; i++) wr_dir[i] = ST_I;
    end else if (serve_rsp) begin
      wr_en  = 1'b1;
      dat_we = (rd_dir[drsp_child] == ST_M);
      wr_dir[drsp_child] = rsp_state;
      if (rd_wait[drsp_child].pend && (rd_wait[drsp_child].goal >= rsp_state)) begin
        wr_wait[drsp_child] = '0;
      end
    end else if (do_grant) begin
      wr_en = 1'b1;
      wr_dir[ureq_child] = req_goal;
    end else if (do_dn) begin
      wr_en = 1'b1;
      wr_wait[dn_child].pend = 1'b1;
      wr_wait[dn_child].goal = dn_goal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      init_busy     <= 1'b1;
      init_idx      <= '0;
      msg_valid     <= 1'b0;
      msg_grant     <= 1'b0;
      msg_child     <= '0;
      msg_addr      <= '0;
      msg_state     <= '0;
      msg_data      <= '0;
      msg_with_data <= 1'b0;
    end else begin
      msg_valid <= do_grant || do_dn;
      if (init_busy) begin
        init_idx <= init_idx + 1'b1;
        if (init_idx == ADDR_W'(DEPTH - 1)) init_busy <= 1'b0;
      end
      if (do_grant) begin
        msg_grant     <= 1'b1;
        msg_child     <= ureq_child;
        msg_addr      <= ureq_addr;
        msg_state     <= ureq_goal;
        msg_data      <= rd_data;
        msg_with_data <= (rd_dir[ureq_child] == ST_I);
      end else if (do_dn) begin
        msg_grant     <= 1'b0;
        msg_child     <= dn_child;
        msg_addr      <= ureq_addr;
        msg_state     <= dn_goal;
        msg_data      <= '0;
        msg_with_data <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/dir_home_chk.sv
module dir_home_chk #(
  parameter int N_CHILD = 4,
  localparam int CW = (N_CHILD > 1) ? $clog2(N_CHILD) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 init_busy,
  input logic                 drsp_valid,
  input logic                 ureq_take,
  input logic [CW-1:0]        ureq_child,
  input logic                 msg_valid,
  input logic                 msg_grant,
  input logic [CW-1:0]        msg_child,
  input logic [1:0]           msg_state,
  input logic [2*N_CHILD-1:0] rd_dir
);
  logic [N_CHILD-1:0] owner_v;

  for (genvar i = 0; i < N_CHILD; i++) begin : g_own
    assign owner_v[i] = (rd_dir[2*i +: 2] == 2'd2);
  end

  AST_RSP_FIRST: assert property (@(posedge clk) disable iff (rst)
    drsp_valid |-> !ureq_take); // R7

  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> !ureq_take); // R9

  AST_GRANT_MSG: assert property (@(posedge clk) disable iff (rst)
    ureq_take |=> (msg_valid && msg_grant && (msg_child == $past(ureq_child)))); // R2

  AST_DN_TARGET: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_grant) |-> (msg_state != 2'd2)); // R3

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    !init_busy |-> $onehot0(owner_v)); // R6

endmodule

bind dir_home dir_home_chk #(.N_CHILD(N_CHILD)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .init_busy (init_busy),
  .drsp_valid(drsp_valid),
  .ureq_take (ureq_take),
  .ureq_child(ureq_child),
  .msg_valid (msg_valid),
  .msg_grant (msg_grant),
  .msg_child (msg_child),
  .msg_state (msg_state),
  .rd_dir    (rd_dir)
);

// File: tb/test_dir_home.sv
module test_dir_home;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int CW = 2;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic          ureq_valid = 1'b0;
  logic [CW-1:0] ureq_child = '0;
  logic [AW-1:0] ureq_addr = '0;
  logic [1:0]    ureq_goal = '0;
  logic          ureq_take;
  logic          drsp_valid = 1'b0;
  logic [CW-1:0] drsp_child = '0;
  logic [AW-1:0] drsp_addr = '0;
  logic [1:0]    drsp_state = '0;
  logic [DW-1:0] drsp_data = '0;
  logic          msg_valid, msg_grant, msg_with_data;
  logic [CW-1:0] msg_child;
  logic [AW-1:0] msg_addr;
  logic [1:0]    msg_state;
  logic [DW-1:0] msg_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int m_dir [DEPTH][N];
  bit m_wp  [DEPTH][N];
  int m_wg  [DEPTH][N];
  bit infl  [DEPTH][N];
  int infg  [DEPTH][N];
  logic [DW-1:0] m_mem [DEPTH];

  bit obs_take, obs_valid, obs_grant, obs_wd;
  logic [DW-1:0] obs_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_home #(.N_CHILD(N), .ADDR_W(AW), .DATA_W(DW)) i_dir_home (
    .clk(clk), .rst(rst),
    .ureq_valid(ureq_valid), .ureq_child(ureq_child), .ureq_addr(ureq_addr),
    .ureq_goal(ureq_goal), .ureq_take(ureq_take),
    .drsp_valid(drsp_valid), .drsp_child(drsp_child), .drsp_addr(drsp_addr),
    .drsp_state(drsp_state), .drsp_data(drsp_data),
    .msg_valid(msg_valid), .msg_grant(msg_grant), .msg_child(msg_child),
    .msg_addr(msg_addr), .msg_state(msg_state), .msg_data(msg_data),
    .msg_with_data(msg_with_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // one cycle: drive at negedge, check take before the edge, message after it
  task automatic step(input bit rv, input int rc, input int ra, input int ry,
                      input bit dv, input int dc, input int da, input int dy,
                      input logic [DW-1:0] dd);
    bit e_take, e_msg, e_grant, e_wd, anyp, compat;
    int e_c, e_st, lim, mcnt;
    logic [DW-1:0] e_dat;
    string ttag;
    ureq_valid = rv; ureq_child = CW'(rc); ureq_addr = AW'(ra); ureq_goal = 2'(ry);
    drsp_valid = dv; drsp_child = CW'(dc); drsp_addr = AW'(da); drsp_state = 2'(dy);
    drsp_data = dd;
    #1;
    e_take = 0; e_msg = 0; e_grant = 0; e_wd = 0; e_c = 0; e_st = 0; e_dat = '0;
    ttag = "R2";
    if (dv) begin
      ttag = "R7";
    end else if (rv) begin
      anyp = 0; compat = 1;
      lim = (ry == 2) ? 0 : 1;
      for (int i = 0; i < N; i++) begin
        if (m_wp[ra][i]) anyp = 1;
        if (i != rc && m_dir[ra][i] > lim) compat = 0;
      end
      if (!anyp && compat) begin
        e_take = 1; e_msg = 1; e_grant = 1; e_c = rc; e_st = ry;
        e_wd = (m_dir[ra][rc] == 0); e_dat = m_mem[ra];
      end else begin
        ttag = anyp ? "R5" : "R1";
        for (int i = 0; i < N; i++) begin
          if (!e_msg && i != rc && m_dir[ra][i] > lim && !m_wp[ra][i]) begin
            e_msg = 1; e_c = i; e_st = lim;
          end
        end
      end
    end
    obs_take = ureq_take;
    chk(obs_take == e_take, ttag, obs_take, e_take);
    @(posedge clk); #1;
    obs_valid = msg_valid; obs_grant = msg_grant; obs_wd = msg_with_data; obs_data = msg_data;
    chk(msg_valid == e_msg, e_grant ? "R2" : "R3", msg_valid, e_msg);
    if (e_msg && msg_valid) begin
      chk(msg_grant == e_grant, "R3", msg_grant, e_grant);
      chk(int'(msg_child) == e_c, e_grant ? "R2" : "R3", msg_child, e_c);
      chk(int'(msg_addr) == ra, "R2", msg_addr, ra);
      chk(int'(msg_state) == e_st, e_grant ? "R2" : "R3", msg_state, e_st);
      if (e_grant) begin
        chk(msg_with_data == e_wd, "R8", msg_with_data, e_wd);
        if (e_wd) chk(msg_data == e_dat, "R4", msg_data, e_dat);
      end
    end
    if (dv) begin
      if (m_dir[da][dc] == 2) m_mem[da] = dd;
      if (m_wp[da][dc] && m_wg[da][dc] >= dy) m_wp[da][dc] = 0;
      m_dir[da][dc] = dy;
    end else if (e_take) begin
      m_dir[ra][rc] = ry;
      if (ry == 2) begin
        mcnt = 0;
        for (int i = 0; i < N; i++) if (m_dir[ra][i] == 2) mcnt++;
        chk(mcnt == 1 && msg_grant && msg_state == 2'd2, "R6", mcnt, 1);
      end
    end else if (e_msg) begin
      m_wp[ra][e_c] = 1; m_wg[ra][e_c] = e_st;
      infl[ra][e_c] = 1; infg[ra][e_c] = e_st;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit p_v;
    int p_c, p_a, p_y;
    void'($urandom(32'd20240611));
    for (int a = 0; a < DEPTH; a++) begin
      m_mem[a] = '0;
      for (int c = 0; c < N; c++) begin
        m_dir[a][c] = 0; m_wp[a][c] = 0; m_wg[a][c] = 0; infl[a][c] = 0; infg[a][c] = 0;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: a request held during the clearing is not taken, no message
    ureq_valid = 1; ureq_child = 0; ureq_addr = 1; ureq_goal = 2'd1;
    for (int k = 0; k < DEPTH; k++) begin
      #1;
      chk(ureq_take == 1'b0, "R9", ureq_take, 0);
      chk(msg_valid == 1'b0, "R9", msg_valid, 0);
      @(negedge clk);
    end
    // directed corners on address 1
    step(1,0,1,1, 0,0,0,0,'0);
    chk(obs_take && obs_wd && obs_data == '0, "R9", obs_data, 0);
    step(1,1,1,1, 0,0,0,0,'0);
    chk(obs_take, "R1", obs_take, 1);
    step(1,2,1,2, 0,0,0,0,'0);
    step(1,2,1,2, 0,0,0,0,'0);
    step(1,2,1,2, 0,0,0,0,'0);
    chk(!obs_take && !obs_valid, "R10", obs_valid, 0);
    step(1,2,1,2, 1,0,1,0,16'h1111);
    chk(!obs_take, "R7", obs_take, 0);
    step(1,2,1,2, 1,1,1,0,16'h2222);
    step(1,2,1,2, 0,0,0,0,'0);
    chk(obs_take && obs_grant && obs_wd, "R8", obs_wd, 1);
    step(1,3,1,1, 0,0,0,0,'0);
    step(1,3,1,1, 1,2,1,1,16'hBEEF);
    step(1,3,1,1, 0,0,0,0,'0);
    chk(obs_take && obs_data == 16'hBEEF, "R4", obs_data, 16'hBEEF);
    step(1,3,1,2, 0,0,0,0,'0);
    step(1,3,1,2, 1,2,1,0,16'h1234);
    step(1,3,1,2, 0,0,0,0,'0);
    chk(obs_take && !obs_wd, "R8", obs_wd, 0);
    step(1,0,1,2, 0,0,0,0,'0);
    step(1,0,1,2, 1,3,1,1,16'h7777);
    step(1,0,1,2, 0,0,0,0,'0);
    chk(!obs_take && !obs_valid, "R5", obs_take, 0);
    step(1,0,1,2, 1,3,1,0,16'h9999);
    step(1,0,1,2, 0,0,0,0,'0);
    chk(obs_take && obs_wd && obs_data == 16'h7777, "R4", obs_data, 16'h7777);
    for (int a = 0; a < DEPTH; a++)
      for (int c = 0; c < N; c++) infl[a][c] = 0;

    // constrained random traffic on addresses 0..3
    p_v = 0; p_c = 0; p_a = 0; p_y = 0;
    for (int n = 0; n < 4000; n++) begin
      bit dv, found;
      int dc, da, dy, off;
      logic [DW-1:0] dd;
      if (!p_v && ($urandom % 3 == 0)) begin
        p_c = $urandom % N; p_a = $urandom % 4;
        if (m_dir[p_a][p_c] == 0) begin p_y = 1 + ($urandom % 2); p_v = 1; end
        else if (m_dir[p_a][p_c] == 1) begin p_y = 2; p_v = 1; end
      end
      dv = 0; dc = 0; da = 0; dy = 0; dd = DW'($urandom);
      if ($urandom % 2 == 0) begin
        found = 0; off = $urandom % 16;
        for (int k = 0; k < 16; k++) begin
          int a2, c2;
          a2 = ((k + off) % 16) / 4; c2 = (k + off) % 4;
          if (!found && infl[a2][c2]) begin
            found = 1; infl[a2][c2] = 0;
            if (m_dir[a2][c2] > infg[a2][c2]) begin
              dv = 1; dc = c2; da = a2; dy = infg[a2][c2];
            end
          end
        end
        if (!found && ($urandom % 6 == 0)) begin
          dc = $urandom % N; da = $urandom % 4;
          if (m_dir[da][dc] > 0 && !(p_v && dc == p_c && da == p_a)) begin
            dv = 1; dy = $urandom % m_dir[da][dc];
          end
        end
      end
      step(p_v, p_c, p_a, p_y, dv, dc, da, dy, dd);
      if (obs_take) p_v = 0;
    end
    ureq_valid = 0; drsp_valid = 0;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule